// File: doc/BRIEF.md
# Iterative Multiply/Divide Peripheral

This block is a byte-addressed arithmetic peripheral. Software loads a 32-bit operand/result register and a 16-bit operand B/divisor register, then writes the control byte to start either an unsigned 16x16 multiply or an unsigned 32/16 divide. The work runs one step per clock: 16 shift-and-add steps for a multiply, 32 restoring-division steps for a divide. The result is written back over the operand/result register. A divide also leaves its remainder in a 16-bit read-only remainder register.

While an operation is in progress, bit 7 of the control byte reads as 1. The bit clears on the same clock edge that commits the final step. On that edge the block also raises a one-cycle `done` pulse, so a polling loop or an interrupt controller can pick up the result. Starting an operation zeroes the remainder register. A multiply start also zeroes the upper half of the operand/result register, because the product accumulates there.

Top module: `mdu_periph`

## Requirements
- R1: After reset, every mapped byte (offsets 0 to 8) reads 0x00 and `done` is low.
- R2: With multiplicand A in offsets 2..3, writing 0x81 to offset 8 produces the 32-bit product A*B in offsets 2..5, with the low byte at offset 2. Offsets 0..1 read zero afterwards.
- R3: A multiply start clears the upper 16 bits of the operand/result register and the remainder, and the remainder reads zero throughout the multiply.
- R4: Writing 0x80 to offset 8 divides the 32-bit value in offsets 2..5 by the divisor. The quotient is left in offsets 2..5 and the remainder in offsets 0..1, low byte first.
- R5: A divide by zero still takes the normal 32 steps. It yields quotient 0xFFFFFFFF and a remainder equal to the low 16 bits of the dividend.
- R6: Bit 7 of offset 8 reads 1 while the block is busy. `done` goes high for exactly one cycle, exactly 16 clocks (multiply) or 32 clocks (divide) after the start write is captured. Bit 7 clears on that same edge.
- R7: Bit 0 of offset 8 is the mode (1 = multiply, 0 = divide) and reads back as written. Writing 0x00 or 0x01 while idle changes only the mode and starts nothing.
- R8: Writes to offsets 0 and 1 (the remainder) are ignored.
- R9: While busy, writes to the control byte (offset 8) and to the divisor (offsets 6..7) are ignored. The operation neither restarts nor changes mode.
- R10: A write to the operand/result bytes while busy does not abort the operation. `done` still arrives on schedule and bit 7 clears.
- R11: Offsets 6..7 hold operand B/divisor, low byte first, and read back as written. Offsets 9 and above read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Byte write strobe, captured on the rising clock edge |
| addr | input | AW (4) | Byte offset for reads and writes |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational from `addr` |
| done | output | 1 | One-cycle pulse when a result is committed |

## Verification
A fault in the step counter or the mode latch shows up at completion. `done` and the clearing of bit 7 then arrive early or late against the fixed 16- or 32-clock window, and the readable mode bit can differ from the one written. A fault in the shift/subtract datapath stays hidden until completion, and then shows as wrong quotient, product or remainder bytes. A start that fails to clear the remainder or the upper operand half can be seen one cycle after the start write.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic {
    MODE_DIV = 1'b0,
    MODE_MUL = 1'b1
  } mdu_mode_e;

  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_MODE_BIT = 0;
endpackage

// File: rtl/mdu_rst_sync.sv
module mdu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/mdu_seq.sv
module mdu_seq
  import mdu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctrl_wr_i,
  input  logic      start_i,
  input  mdu_mode_e mode_i,
  output logic      busy_o,
  output mdu_mode_e mode_o,
  output logic      done_o
);
  localparam int MUL_STEPS = W;
  localparam int DIV_STEPS = 2 * W;
  localparam int CW        = $clog2(DIV_STEPS);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  mdu_mode_e     mode_q, mode_d;
  logic          last_step;

  always_comb begin
    if (mode_q == MODE_MUL) begin
      last_step = (cnt_q == CW'(MUL_STEPS - 1));
    end else begin
      last_step = (cnt_q == CW'(DIV_STEPS - 1));
    end
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    done_d = 1'b0;
    if (busy_q) begin
      cnt_d = cnt_q + CW'(1);
      if (last_step) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else begin
      if (ctrl_wr_i) begin
        mode_d = mode_i;
      end
      if (start_i) begin
        busy_d = 1'b1;
        cnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      mode_q <= MODE_DIV;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign busy_o = busy_q;
  assign mode_o = mode_q;
  assign done_o = done_q;
endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int W = 16
) (
  input  mdu_mode_e      mode_i,
  input  logic [2*W-1:0] opr_i,
  input  logic [W-1:0]   rem_i,
  input  logic [W-1:0]   dvs_i,
  output logic [2*W-1:0] opr_o,
  output logic [W-1:0]   rem_o
);
  logic [W:0]   mul_sum;
  logic [W:0]   div_part;
  logic [W:0]   div_diff;
  logic         div_fits;

  always_comb begin
    mul_sum  = {1'b0, opr_i[2*W-1:W]} + {1'b0, (opr_i[0] ? dvs_i : {W{1'b0}})};
    div_part = {rem_i, opr_i[2*W-1]};
    div_fits = (div_part >= {1'b0, dvs_i});
    div_diff = div_part - {1'b0, dvs_i};
    if (mode_i == MODE_MUL) begin
      opr_o = {mul_sum, opr_i[W-1:1]};
      rem_o = rem_i;
    end else begin
      opr_o = {opr_i[2*W-2:0], div_fits};
      rem_o = div_fits ? div_diff[W-1:0] : div_part[W-1:0];
    end
  end
endmodule

// File: rtl/mdu_periph.sv
module mdu_periph
  import mdu_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          done
);
  localparam int NB         = W / 8;
  localparam int OPR_BASE   = NB;
  localparam int DVS_BASE   = 3 * NB;
  localparam int CTRL_ADDR  = 4 * NB;
  localparam int DATA_BYTES = 4 * NB;

  logic           rst_sn;
  logic [2*W-1:0] opr_q, opr_d, opr_step;
  logic [W-1:0]   rem_q, rem_d, rem_step;
  logic [W-1:0]   dvs_q, dvs_d;
  logic [2*NB-1:0] wr_opr;
  logic [NB-1:0]   wr_dvs;
  logic           ctrl_wr;
  logic           busy;
  logic           start_s;
  logic           start_mul;
  mdu_mode_e      mode_s;
  mdu_mode_e      mode_wr;
  logic           opr_en, rem_en, dvs_en;
  logic [4*W-1:0] data_flat;
  int             rd_idx;

  mdu_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign ctrl_wr   = wr_en && (int'(addr) == CTRL_ADDR);
  assign mode_wr   = mdu_mode_e'(wdata[CTRL_MODE_BIT]);
  assign start_s   = ctrl_wr && wdata[CTRL_EN_BIT] && !busy;
  assign start_mul = start_s && (mode_wr == MODE_MUL);

  genvar gi;
  generate
    for (gi = 0; gi < 2 * NB; gi++) begin : g_opr_lane
      assign wr_opr[gi] = wr_en && (int'(addr) == OPR_BASE + gi);
    end
    for (gi = 0; gi < NB; gi++) begin : g_dvs_lane
      assign wr_dvs[gi] = wr_en && (int'(addr) == DVS_BASE + gi);
    end
  endgenerate

  mdu_seq #(.W(W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sn),
    .ctrl_wr_i (ctrl_wr),
    .start_i   (start_s),
    .mode_i    (mode_wr),
    .busy_o    (busy),
    .mode_o    (mode_s),
    .done_o    (done)
  );

  mdu_datapath #(.W(W)) u_dp (
    .mode_i (mode_s),
    .opr_i  (opr_q),
    .rem_i  (rem_q),
    .dvs_i  (dvs_q),
    .opr_o  (opr_step),
    .rem_o  (rem_step)
  );

  assign opr_en = busy || start_mul || (|wr_opr);
  assign rem_en = busy || start_s;
  assign dvs_en = (|wr_dvs) && !busy;

  always_comb begin
    opr_d = opr_q;
    rem_d = rem_q;
    dvs_d = dvs_q;
    if (busy) begin
      opr_d = opr_step;
      rem_d = rem_step;
    end
    if (start_s) begin
      rem_d = '0;
      if (start_mul) begin
        opr_d[2*W-1:W] = '0;
      end
    end
    for (int i = 0; i < 2 * NB; i++) begin
      if (wr_opr[i]) begin
        opr_d[8*i +: 8] = wdata;
      end
    end
    for (int i = 0; i < NB; i++) begin
      if (wr_dvs[i]) begin
        dvs_d[8*i +: 8] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      opr_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
    end else begin
      if (opr_en) opr_q <= opr_d;
      if (rem_en) rem_q <= rem_d;
      if (dvs_en) dvs_q <= dvs_d;
    end
  end

  assign data_flat = {dvs_q, opr_q, rem_q};
  assign rd_idx    = int'(addr);

  always_comb begin
    rdata = 8'h00;
    if (rd_idx < DATA_BYTES) begin
      rdata = data_flat[rd_idx*8 +: 8];
    end else if (rd_idx == CTRL_ADDR) begin
      rdata = 8'h00;
      rdata[CTRL_EN_BIT]   = busy;
      rdata[CTRL_MODE_BIT] = mode_s;
    end
  end
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         mode,
  input logic         done,
  input logic         start,
  input logic         start_mul,
  input logic [W-1:0] rem,
  input logic [W-1:0] opr_hi,
  input logic [W-1:0] dvs
);
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_at_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_only_at_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy);

  p_start_clears_rem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && rem == '0));

  p_mul_clears_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_mul |=> (opr_hi == '0));

  p_mul_rem_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode) |-> (rem == '0));

  p_dvs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(dvs));

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode));
endmodule

bind mdu_periph mdu_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .busy      (busy),
  .mode      (mode_s),
  .done      (done),
  .start     (start_s),
  .start_mul (start_mul),
  .rem       (rem_q),
  .opr_hi    (opr_q[2*W-1:W]),
  .dvs       (dvs_q)
);

// File: tb/mdu_periph_tb.sv
`timescale 1ns/1ps
module mdu_periph_tb;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] addr;
  logic [3:0] drv_addr;
  logic [3:0] mon_addr;
  logic       mon_own;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       done;

  int checks;
  int fails;
  int cyc;
  int sent;
  int acked;

  typedef struct {
    bit          is_mul;
    bit          chk_data;
    logic [31:0] exp_opr;
    logic [15:0] exp_rem;
    int          start_cyc;
    int          lat;
    string       req;
    string       lat_req;
  } item_t;

  item_t sb_q[$];

  assign addr = mon_own ? mon_addr : drv_addr;

  mdu_periph u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .done  (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en    = 1'b1;
    drv_addr = a;
    wdata    = d;
    @(negedge clk);
    wr_en    = 1'b0;
  endtask

  task automatic drv_rd(input logic [3:0] a, output logic [7:0] d);
    drv_addr = a;
    #1;
    d = rdata;
  endtask

  task automatic mon_rd(input logic [3:0] a, output logic [7:0] d);
    mon_addr = a;
    #1;
    d = rdata;
  endtask

  // Monitor: pops expected items at each done pulse and compares
  initial begin
    logic [7:0] b0, b1, b2, b3;
    item_t it;
    mon_own  = 1'b0;
    mon_addr = '0;
    forever begin
      @(negedge clk);
      if (done === 1'b1) begin
        if (sb_q.size() == 0) begin
          check("R6 unexpected done", 32'd1, 32'd0);
        end else begin
          it = sb_q.pop_front();
          check(it.lat_req, 32'(cyc - it.start_cyc), 32'(it.lat));
          mon_own = 1'b1;
          mon_rd(4'd8, b0);
          check("R6 busy bit clear at done", {31'd0, b0[7]}, 32'd0);
          check("R7 mode bit at done", {31'd0, b0[0]}, {31'd0, it.is_mul});
          if (it.chk_data) begin
            mon_rd(4'd2, b0); mon_rd(4'd3, b1); mon_rd(4'd4, b2); mon_rd(4'd5, b3);
            check(it.req, {b3, b2, b1, b0}, it.exp_opr);
            mon_rd(4'd0, b0); mon_rd(4'd1, b1);
            check(it.req, {16'd0, b1, b0}, {16'd0, it.exp_rem});
          end
          mon_own = 1'b0;
        end
        acked++;
      end
    end
  end

  // Driver: loads operands, starts, pushes expectation, optionally pokes while busy
  task automatic run_op(input bit is_mul, input logic [31:0] a, input logic [15:0] b,
                        input int poke);
    item_t it;
    logic [7:0] rd;
    bus_wr(4'd6, b[7:0]);
    bus_wr(4'd7, b[15:8]);
    bus_wr(4'd2, a[7:0]);
    bus_wr(4'd3, a[15:8]);
    bus_wr(4'd4, a[23:16]);
    bus_wr(4'd5, a[31:24]);
    it.is_mul   = is_mul;
    it.chk_data = (poke != 2);
    if (is_mul) begin
      it.exp_opr = {16'd0, a[15:0]} * {16'd0, b};
      it.exp_rem = 16'd0;
      it.lat     = 16;
      it.req     = "R2";
    end else if (b == 16'd0) begin
      it.exp_opr = 32'hFFFF_FFFF;
      it.exp_rem = a[15:0];
      it.lat     = 32;
      it.req     = "R5";
    end else begin
      it.exp_opr = a / {16'd0, b};
      it.exp_rem = 16'(a % {16'd0, b});
      it.lat     = 32;
      it.req     = "R4";
    end
    it.lat_req = (poke == 2) ? "R10 latency" : (poke == 1) ? "R9 latency" : "R6 latency";
    bus_wr(4'd8, is_mul ? 8'h81 : 8'h80);
    it.start_cyc = cyc;
    sb_q.push_back(it);
    sent++;
    drv_rd(4'd8, rd);
    check("R6 busy bit set", {31'd0, rd[7]}, 32'd1);
    if (is_mul) begin
      drv_rd(4'd0, rd);
      check("R3 rem low zero while mul", {24'd0, rd}, 32'd0);
      drv_rd(4'd1, rd);
      check("R3 rem high zero while mul", {24'd0, rd}, 32'd0);
    end
    if (poke == 1) begin
      bus_wr(4'd8, is_mul ? 8'h80 : 8'h81);
      bus_wr(4'd6, 8'hEE);
      bus_wr(4'd7, 8'hDD);
    end else if (poke == 2) begin
      bus_wr(4'd2, 8'h77);
    end
    wait (acked == sent);
    @(negedge clk);
    if (poke == 1) begin
      drv_rd(4'd6, rd);
      check("R9 divisor low kept", {24'd0, rd}, {24'd0, b[7:0]});
      drv_rd(4'd7, rd);
      check("R9 divisor high kept", {24'd0, rd}, {24'd0, b[15:8]});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    checks   = 0;
    fails    = 0;
    sent     = 0;
    acked    = 0;
    rst_n    = 1'b0;
    wr_en    = 1'b0;
    drv_addr = '0;
    wdata    = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 done low", {31'd0, done}, 32'd0);
    for (int i = 0; i < 9; i++) begin
      drv_rd(4'(i), rd);
      check("R1 reset byte", {24'd0, rd}, 32'd0);
    end

    // R7 mode-only control writes
    bus_wr(4'd8, 8'h01);
    drv_rd(4'd8, rd);
    check("R7 mode write mul", {24'd0, rd}, 32'h01);
    bus_wr(4'd8, 8'h00);
    drv_rd(4'd8, rd);
    check("R7 mode write div", {24'd0, rd}, 32'h00);

    // R11 divisor readback and unmapped offsets
    bus_wr(4'd6, 8'h3C);
    bus_wr(4'd7, 8'hA5);
    drv_rd(4'd6, rd);
    check("R11 divisor low", {24'd0, rd}, 32'h3C);
    drv_rd(4'd7, rd);
    check("R11 divisor high", {24'd0, rd}, 32'hA5);
    bus_wr(4'd12, 8'hFF);
    drv_rd(4'd12, rd);
    check("R11 unmapped read", {24'd0, rd}, 32'h00);
    drv_rd(4'd9, rd);
    check("R11 offset 9 read", {24'd0, rd}, 32'h00);

    // Multiplies (upper half preloaded to show R3 clearing)
    run_op(1'b1, 32'hDEAD_1234, 16'h5678, 0);
    run_op(1'b1, 32'h0000_FFFF, 16'hFFFF, 0);
    run_op(1'b1, 32'hFFFF_0000, 16'hBEEF, 0);

    // Divides
    run_op(1'b0, 32'h1234_5678, 16'h1234, 0);
    run_op(1'b0, 32'hFFFF_FFFF, 16'h0001, 0);
    run_op(1'b0, 32'h0000_0005, 16'h0007, 0);
    run_op(1'b0, 32'h8000_0000, 16'hFFFF, 0);

    // R5 divide by zero
    run_op(1'b0, 32'hABCD_1234, 16'h0000, 0);

    // R8 remainder writes ignored (remainder now 0x1234)
    bus_wr(4'd0, 8'h55);
    bus_wr(4'd1, 8'hAA);
    drv_rd(4'd0, rd);
    check("R8 rem low unchanged", {24'd0, rd}, 32'h34);
    drv_rd(4'd1, rd);
    check("R8 rem high unchanged", {24'd0, rd}, 32'h12);

    // R9 control and divisor writes while busy
    run_op(1'b0, 32'h00FF_FF00, 16'h0101, 1);
    run_op(1'b1, 32'h0000_00FF, 16'h0102, 1);

    // R10 operand write while busy: schedule kept
    run_op(1'b1, 32'h0000_4321, 16'h1111, 2);

    repeat (5) @(negedge clk);
    check("R6 queue drained", 32'(sb_q.size()), 32'd0);
    finish_run();
  end
endmodule